// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block decides, for a single memory request, whether a conditional-store or an exclusive access is allowed to go ahead. It takes the outcome of an address translation that has already happened elsewhere, the page's read and write permissions, the cache attribute code of the target page and a six-bit atomic policy word. From these it produces one exception decision per request: a strobe, and a cause code that is zero when the access is allowed.

The policy word is three two-bit fields. The cache behaviour of the page picks which field applies. A field of zero forbids atomic access to that kind of page. Isolated pages always fault. When the core has no data cache, every page is handled as uncached. The decision is registered, so the result of a request presented in one cycle appears in the next.

Top module: `atomic_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `chk_done`, `exc_vld` and `exc_cause` are all zero.
- R2: `chk_done` is high for exactly one cycle, in the cycle after each cycle with `req_vld` high, and is low otherwise. `exc_vld` is never high without `chk_done`.
- R3: A nonzero `xlat_cause` is reported unchanged as `exc_cause` with `exc_vld` high. It takes priority over every other check.
- R4: In conditional-store mode (`excl_mode` = 0), a page missing read or write permission faults with the store-prohibited cause (default 29), never with a load-prohibited cause.
- R5: In exclusive mode (`excl_mode` = 1), the permission bits have no effect on the result.
- R6: The page attribute selects a field of `atomic_ctl`: uncached (default code 1) uses bits [1:0], write-through (default code 2) uses bits [3:2], and write-back (default code 3) uses bits [5:4]. A selected field of 2'b00 faults. Any nonzero field lets the request pass.
- R7: A fault from a zero field carries the load/store-error cause (default 3) in conditional-store mode and the exclusive-error cause (default 8) in exclusive mode.
- R8: An isolated page (default code 4) always faults with the load/store-error cause, in both modes and whatever `atomic_ctl` holds.
- R9: With `dcache_present` low, the page attribute is ignored and the uncached field, bits [1:0], is applied. This also holds for the isolated code.
- R10: Attribute codes other than the four listed never raise a policy fault.
- R11: When no fault is found, `exc_vld` is low and `exc_cause` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A request is presented this cycle |
| xlat_cause | input | CAUSE_W (6) | Translation fault cause, zero when translation succeeded |
| perm_rd | input | 1 | Page is readable |
| perm_wr | input | 1 | Page is writable |
| page_attr | input | ATTR_W (4) | Cache attribute code of the page |
| atomic_ctl | input | 6 | Atomic policy word, three two-bit fields |
| dcache_present | input | 1 | A data cache is configured |
| excl_mode | input | 1 | 1 = exclusive access, 0 = conditional store |
| chk_done | output | 1 | Decision strobe, one per request |
| exc_vld | output | 1 | The checked request faults |
| exc_cause | output | CAUSE_W (6) | Cause of the fault, zero when none |

## Verification
Every result is due exactly one clock edge after the request is presented. The bench drives a request on the falling edge, and the rising edge that follows captures it. `chk_done`, `exc_vld` and `exc_cause` are read 2 ns after that rising edge. The driver queues the expected decision as it drives, and the monitor requires `chk_done` in exactly those sample points where an item is waiting. The same sample point also shows that idle cycles produce no strobe.

// File: rtl/atom_chk_pkg.sv
package atom_chk_pkg;

   localparam int unsigned CTL_FIELD_W = 2;
   localparam int unsigned CTL_FIELDS  = 3;
   localparam int unsigned CTL_W       = CTL_FIELD_W * CTL_FIELDS;

   // Effective page class after data-cache presence is taken into account.
   // The field index of the first three classes equals their position.
   typedef enum logic [2:0] {
      CLS_UNCACHED = 3'd0,
      CLS_WTHRU    = 3'd1,
      CLS_WBACK    = 3'd2,
      CLS_ISOLATE  = 3'd3,
      CLS_OTHER    = 3'd4
   } page_cls_e;

endpackage

// File: rtl/atom_class_decode.sv
module atom_class_decode
   import atom_chk_pkg::*;
#(
   parameter int unsigned ATTR_W       = 4,
   parameter logic [ATTR_W-1:0] ATTR_UNCACHED = 1,
   parameter logic [ATTR_W-1:0] ATTR_WTHRU    = 2,
   parameter logic [ATTR_W-1:0] ATTR_WBACK    = 3,
   parameter logic [ATTR_W-1:0] ATTR_ISOLATE  = 4
) (
   input  logic [ATTR_W-1:0] page_attr,
   input  logic              dcache_present,
   output page_cls_e         page_cls
);

   initial begin
      if (ATTR_UNCACHED == ATTR_WTHRU || ATTR_UNCACHED == ATTR_WBACK ||
          ATTR_UNCACHED == ATTR_ISOLATE || ATTR_WTHRU == ATTR_WBACK ||
          ATTR_WTHRU == ATTR_ISOLATE || ATTR_WBACK == ATTR_ISOLATE)
         $error("atom_class_decode: attribute codes must be distinct");
   end

   always_comb begin
      if (!dcache_present) begin
         page_cls = CLS_UNCACHED;  // R9: no cache, uncached field rules
      end else if (page_attr == ATTR_UNCACHED) begin
         page_cls = CLS_UNCACHED;
      end else if (page_attr == ATTR_WTHRU) begin
         page_cls = CLS_WTHRU;
      end else if (page_attr == ATTR_WBACK) begin
         page_cls = CLS_WBACK;
      end else if (page_attr == ATTR_ISOLATE) begin
         page_cls = CLS_ISOLATE;
      end else begin
         page_cls = CLS_OTHER;
      end
   end

endmodule

// File: rtl/atom_field_sel.sv
module atom_field_sel
   import atom_chk_pkg::*;
#(
   parameter int unsigned FIELDS  = CTL_FIELDS,
   parameter int unsigned FIELD_W = CTL_FIELD_W,
   localparam int unsigned WORD_W = FIELDS * FIELD_W
) (
   input  logic [WORD_W-1:0] atomic_ctl,
   input  page_cls_e         page_cls,
   output logic              field_zero
);

   initial begin
      if (FIELDS != 3)
         $error("atom_field_sel: exactly three cacheable classes are decoded");
      if (FIELD_W == 0)
         $error("atom_field_sel: field width must be nonzero");
   end

   logic [FIELDS-1:0] zero_vec;

   // One zero detector per policy field; field g serves class g (R6).
   for (genvar g = 0; g < FIELDS; g++) begin : g_fld
      assign zero_vec[g] = (atomic_ctl[g*FIELD_W +: FIELD_W] == '0);
   end

   always_comb begin
      unique case (page_cls)
         CLS_UNCACHED: field_zero = zero_vec[0];
         CLS_WTHRU:    field_zero = zero_vec[1];
         CLS_WBACK:    field_zero = zero_vec[2];
         default:      field_zero = 1'b0;
      endcase
   end

endmodule

// File: rtl/atom_cause_pick.sv
module atom_cause_pick
   import atom_chk_pkg::*;
#(
   parameter int unsigned CAUSE_W = 6,
   parameter logic [CAUSE_W-1:0] CAUSE_STORE_PROH = 29,
   parameter logic [CAUSE_W-1:0] CAUSE_LS_ERR     = 3,
   parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR   = 8
) (
   input  logic [CAUSE_W-1:0] xlat_cause,
   input  logic               perm_rd,
   input  logic               perm_wr,
   input  logic               excl_mode,
   input  page_cls_e          page_cls,
   input  logic               field_zero,
   output logic               fault,
   output logic [CAUSE_W-1:0] cause
);

   always_comb begin
      fault = 1'b0;
      cause = '0;
      if (xlat_cause != '0) begin
         fault = 1'b1;                      // R3: translation first
         cause = xlat_cause;
      end else if (!excl_mode && !(perm_rd && perm_wr)) begin
         fault = 1'b1;                      // R4: store-prohibited only
         cause = CAUSE_STORE_PROH;
      end else if (page_cls == CLS_ISOLATE) begin
         fault = 1'b1;                      // R8
         cause = CAUSE_LS_ERR;
      end else if (field_zero) begin
         fault = 1'b1;                      // R7
         cause = excl_mode ? CAUSE_EXCL_ERR : CAUSE_LS_ERR;
      end
   end

   // R11: a fault always carries a nonzero cause, a pass carries none
   always_comb begin
      a_r11_cause_matches_fault : assert (fault == (cause != '0));
   end

endmodule

// File: rtl/atom_out_stage.sv
module atom_out_stage #(
   parameter int unsigned CAUSE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic               fault,
   input  logic [CAUSE_W-1:0] cause,
   output logic               chk_done,
   output logic               exc_vld,
   output logic [CAUSE_W-1:0] exc_cause
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_done  <= 1'b0;
         exc_vld   <= 1'b0;
         exc_cause <= '0;
      end else begin
         chk_done  <= req_vld;
         exc_vld   <= req_vld && fault;
         exc_cause <= (req_vld && fault) ? cause : '0;
      end
   end

   a_r2_exc_within_done : assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |-> chk_done);

   a_r11_idle_cause_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !exc_vld |-> exc_cause == '0);

endmodule

// File: rtl/atomic_gate.sv
module atomic_gate
   import atom_chk_pkg::*;
#(
   parameter int unsigned CAUSE_W = 6,
   parameter int unsigned ATTR_W  = 4,
   parameter logic [ATTR_W-1:0]  ATTR_UNCACHED    = 1,
   parameter logic [ATTR_W-1:0]  ATTR_WTHRU       = 2,
   parameter logic [ATTR_W-1:0]  ATTR_WBACK       = 3,
   parameter logic [ATTR_W-1:0]  ATTR_ISOLATE     = 4,
   parameter logic [CAUSE_W-1:0] CAUSE_STORE_PROH = 29,
   parameter logic [CAUSE_W-1:0] CAUSE_LS_ERR     = 3,
   parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic [CAUSE_W-1:0] xlat_cause,
   input  logic               perm_rd,
   input  logic               perm_wr,
   input  logic [ATTR_W-1:0]  page_attr,
   input  logic [CTL_W-1:0]   atomic_ctl,
   input  logic               dcache_present,
   input  logic               excl_mode,
   output logic               chk_done,
   output logic               exc_vld,
   output logic [CAUSE_W-1:0] exc_cause
);

   initial begin
      if (CAUSE_W < 2 || ATTR_W < 3)
         $error("atomic_gate: cause or attribute width too small");
      if (CAUSE_STORE_PROH == '0 || CAUSE_LS_ERR == '0 || CAUSE_EXCL_ERR == '0)
         $error("atomic_gate: cause codes must be nonzero");
      if (CAUSE_LS_ERR == CAUSE_EXCL_ERR || CAUSE_LS_ERR == CAUSE_STORE_PROH ||
          CAUSE_EXCL_ERR == CAUSE_STORE_PROH)
         $error("atomic_gate: cause codes must be distinct");
   end

   page_cls_e          page_cls;
   logic               field_zero;
   logic               fault;
   logic [CAUSE_W-1:0] cause;

   atom_class_decode #(
      .ATTR_W(ATTR_W), .ATTR_UNCACHED(ATTR_UNCACHED), .ATTR_WTHRU(ATTR_WTHRU),
      .ATTR_WBACK(ATTR_WBACK), .ATTR_ISOLATE(ATTR_ISOLATE)
   ) u_cls (
      .page_attr(page_attr), .dcache_present(dcache_present), .page_cls(page_cls)
   );

   atom_field_sel #(.FIELDS(CTL_FIELDS), .FIELD_W(CTL_FIELD_W)) u_fld (
      .atomic_ctl(atomic_ctl), .page_cls(page_cls), .field_zero(field_zero)
   );

   atom_cause_pick #(
      .CAUSE_W(CAUSE_W), .CAUSE_STORE_PROH(CAUSE_STORE_PROH),
      .CAUSE_LS_ERR(CAUSE_LS_ERR), .CAUSE_EXCL_ERR(CAUSE_EXCL_ERR)
   ) u_pick (
      .xlat_cause(xlat_cause), .perm_rd(perm_rd), .perm_wr(perm_wr),
      .excl_mode(excl_mode), .page_cls(page_cls), .field_zero(field_zero),
      .fault(fault), .cause(cause)
   );

   atom_out_stage #(.CAUSE_W(CAUSE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .fault(fault), .cause(cause),
      .chk_done(chk_done), .exc_vld(exc_vld), .exc_cause(exc_cause)
   );

   a_r2_idle_no_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !chk_done && !exc_vld);

   a_r3_xlat_passthrough : assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && xlat_cause != '0 |=> exc_vld && exc_cause == $past(xlat_cause));

   a_r8_isolate_faults : assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && xlat_cause == '0 && dcache_present && page_attr == ATTR_ISOLATE &&
      (excl_mode || (perm_rd && perm_wr))
      |=> exc_vld && exc_cause == CAUSE_LS_ERR);

   a_r9_nocache_uncached_field : assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && xlat_cause == '0 && !dcache_present && excl_mode &&
      atomic_ctl[1:0] == 2'b00
      |=> exc_vld && exc_cause == CAUSE_EXCL_ERR);

   a_r4_store_prohibited : assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && xlat_cause == '0 && !excl_mode && !(perm_rd && perm_wr)
      |=> exc_vld && exc_cause == CAUSE_STORE_PROH);

endmodule

// File: tb/tb_atomic_gate.sv
`timescale 1ns/1ps
module tb_atomic_gate;

   localparam int CW = 6;
   localparam logic [CW-1:0] C_SP = 29, C_LS = 3, C_EX = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_vld = 1'b0;
   logic [CW-1:0] xlat_cause = '0;
   logic          perm_rd = 1'b0, perm_wr = 1'b0;
   logic [3:0]    page_attr = '0;
   logic [5:0]    atomic_ctl = '0;
   logic          dcache_present = 1'b0, excl_mode = 1'b0;
   logic          chk_done, exc_vld;
   logic [CW-1:0] exc_cause;

   int checks = 0;
   int failures = 0;
   logic [CW-1:0] exp_q[$];
   string         tag_q[$];

   always #4 clk = ~clk;  // 125 MHz

   atomic_gate dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .xlat_cause(xlat_cause),
      .perm_rd(perm_rd), .perm_wr(perm_wr), .page_attr(page_attr),
      .atomic_ctl(atomic_ctl), .dcache_present(dcache_present),
      .excl_mode(excl_mode), .chk_done(chk_done), .exc_vld(exc_vld),
      .exc_cause(exc_cause)
   );

   // Expected cause per the requirements; 0 means the request passes.
   function automatic logic [CW-1:0] model(logic [CW-1:0] xc, logic r, logic w,
         logic [3:0] at, logic [5:0] ctl, logic dc, logic ex);
      logic [3:0] a;
      if (xc != 0) return xc;                                 // R3
      if (!ex && !(r && w)) return C_SP;                      // R4, R5
      a = dc ? at : 4'd1;                                     // R9
      if (a == 4'd4) return C_LS;                             // R8
      if ((a == 4'd1 && ctl[1:0] == 0) || (a == 4'd2 && ctl[3:2] == 0) ||
          (a == 4'd3 && ctl[5:4] == 0))                       // R6
         return ex ? C_EX : C_LS;                             // R7
      return '0;                                              // R10, R11
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(string tag, logic [CW-1:0] xc, logic r, logic w,
         logic [3:0] at, logic [5:0] ctl, logic dc, logic ex);
      @(negedge clk);
      req_vld = 1'b1; xlat_cause = xc; perm_rd = r; perm_wr = w;
      page_attr = at; atomic_ctl = ctl; dcache_present = dc; excl_mode = ex;
      exp_q.push_back(model(xc, r, w, at, ctl, dc, ex));
      tag_q.push_back(tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_vld = 1'b0;
         xlat_cause = 6'h3f;  // would fault if it were taken
      end
   endtask

   // Monitor: results are due 2 ns after the edge that captured the request.
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [CW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({"R2 done ", t}, chk_done, 1);
            check({t, " vld"}, exc_vld, e != 0);
            check({t, " cause"}, exc_cause, e);
         end else begin
            check("R2 idle done", chk_done, 0);
            check("R2 idle vld", exc_vld, 0);
         end
      end
   end

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #20;
      check("R1 done in reset", chk_done, 0);
      check("R1 vld in reset", exc_vld, 0);
      check("R1 cause in reset", exc_cause, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check("R1 cause after reset", exc_cause, 0);

      drive("R3 xlat prio", 6'd12, 0, 0, 4'd4, 6'd0, 1, 0);
      drive("R3 xlat excl", 6'd5, 1, 1, 4'd1, 6'd0, 1, 1);
      drive("R4 no write", 0, 1, 0, 4'd1, 6'h3f, 1, 0);
      drive("R4 no read", 0, 0, 1, 4'd4, 6'h3f, 1, 0);
      drive("R5 excl ignores perm", 0, 0, 0, 4'd1, 6'b000001, 1, 1);
      drive("R6 uncached zero", 0, 1, 1, 4'd1, 6'b111100, 1, 0);
      drive("R6 uncached ok", 0, 1, 1, 4'd1, 6'b000010, 1, 0);
      drive("R6 wthru zero", 0, 1, 1, 4'd2, 6'b110011, 1, 0);
      drive("R6 wthru ok", 0, 1, 1, 4'd2, 6'b000100, 1, 0);
      drive("R7 wback zero excl", 0, 1, 1, 4'd3, 6'b001111, 1, 1);
      drive("R6 wback ok", 0, 1, 1, 4'd3, 6'b100000, 1, 0);
      idle(2);
      drive("R8 isolate cs", 0, 1, 1, 4'd4, 6'h3f, 1, 0);
      drive("R8 isolate excl", 0, 0, 0, 4'd4, 6'h3f, 1, 1);
      drive("R9 nocache ok", 0, 1, 1, 4'd3, 6'b000011, 0, 0);
      drive("R9 nocache isolate zero", 0, 1, 1, 4'd4, 6'b111100, 0, 1);
      drive("R9 nocache isolate ok", 0, 1, 1, 4'd4, 6'b000001, 0, 0);
      drive("R10 other attr", 0, 1, 1, 4'd0, 6'd0, 1, 1);
      drive("R10 other attr hi", 0, 1, 1, 4'd9, 6'd0, 1, 0);
      drive("R11 clean pass", 0, 1, 1, 4'd2, 6'h3f, 1, 1);
      idle(3);

      for (int i = 0; i < 400; i++) begin
         logic [CW-1:0] xc;
         xc = ($urandom_range(3) == 0) ? CW'($urandom_range(63)) : '0;
         drive("R3 R7 random", xc, 1'($urandom), 1'($urandom),
               4'($urandom_range(7)), 6'($urandom), 1'($urandom), 1'($urandom));
         if ($urandom_range(4) == 0) idle(1);
      end
      idle(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule